// File: doc/BRIEF.md
# I2S transmit serializer

This block is the transmit half of an I2S bus master. It runs on the master clock, produces the bit clock and the word-select line, and sends audio samples on a serial data line. The samples come from a transmit FIFO that sits outside the block. The FIFO holds 32-bit words in left, right, left, right order. A mono stream reaches the block with each sample written twice. The register bank, the FIFO and the interrupt logic are also outside the block. It only transmits.

Two configuration fields control the output. An 8-bit ratio sets the bit clock to the master clock divided by 2*(ratio+2). With the master clock at 256 times the sample rate, ratio 0 gives 32-bit stereo frames and ratio 2 gives 16-bit stereo frames. This is how rates from 8 kHz to 96 kHz are reached. A 6-bit resolution field sets the slot width. Only that many low-order bits of each FIFO word are sent. Each time transmit is enabled, one full frame of zeros goes out first, starting with the left slot, and then the queued data follows.

Top module: `i2s_tx_serializer`

## Requirements
- R1: While enabled, `sck_o` has a period of 2*(ratio+2) master clock cycles, with equal low and high phases. After enable rises it stays low for the first ratio+2 cycles.
- R2: Each slot lasts W bit clocks. W is the resolution value when it is between 1 and 32, and 32 when it is 0 or above 32. `ws_o` is 0 for the left slot and 1 for the right slot. `ws_o` changes only together with a falling edge of `sck_o`.
- R3: Data is sent MSB first. The MSB goes out in the second bit clock of its slot, one bit after the `ws_o` change. The LSB goes out in the first bit clock of the following slot. Only bits W-1..0 of a word are sent. `sd_o` changes only with a falling edge of `sck_o`.
- R4: After every enable, the first frame (a left slot followed by a right slot) carries only zeros, and no FIFO word is consumed during it. The first pop happens at the falling edge that follows the 2W-th rising edge of `sck_o`.
- R5: The FIFO is show-ahead. `fifo_pop_o` is a one-cycle pulse in the cycle just before the falling edge of `sck_o` that starts a slot. `fifo_data_i` is taken in that same cycle. Words are used in FIFO order, alternating left and right.
- R6: If `fifo_empty_i` is 1 when a slot starts, that slot sends zeros and no pop is issued.
- R7: While `tx_en_i` is 0, `sck_o`, `ws_o`, `sd_o` and `fifo_pop_o` are 0 from the next cycle on, and all counters return to their start state.
- R8: Ratio and resolution are captured while `tx_en_i` is 0. Changes made while it is 1 have no effect until the next enable.
- R9: An asynchronous reset (`rst_ni` low) sets every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| ratio_i | input | RATIO_W (8) | Bit clock divider ratio |
| res_i | input | RES_W (6) | Sample resolution in bits |
| fifo_data_i | input | DATA_W (32) | Head word of the show-ahead FIFO |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_pop_o | output | 1 | FIFO read strobe |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select (0 = left) |
| sd_o | output | 1 | Serial data |

## Verification
If the divider count is wrong, the spacing between rising edges of the bit clock is wrong, and this shows up at the first edge after enable. If the bit index or the channel state is wrong, word-select toggles at the wrong rising edge, which shows within one slot. A wrong shift or alignment shows as a mismatched bit in the first data slot after the zero frame. If the zero-frame flag is wrong, the first pop moves away from rising edge 2W, or data appears in the first frame. The bench models the expected word-select and data value at every rising bit-clock edge and checks each one, so a fault is reported at the bit where it first appears.
// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // out-of-range resolution selects the full word
  function automatic int unsigned clamp_width(input int unsigned res, input int unsigned max_w);
    if (res == 0 || res > max_w) return max_w;
    return res;
  endfunction

endpackage
// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int RATIO_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               sck_o,
  output logic               fall_o
);
  localparam int CNT_W = RATIO_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_w;
  logic             term_w;

  // half period is ratio+2 cycles, so the counter ends at ratio+1
  assign last_w = CNT_W'(ratio_i) + CNT_W'(1);
  assign term_w = (cnt_q == last_w);
  assign fall_o = run_i && term_w && sck_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (term_w) begin
      cnt_q <= '0;
      sck_o <= ~sck_o;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule
// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer
  import i2s_tx_pkg::*;
#(
  parameter int BIT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [BIT_W-1:0] width_i,
  output logic             ws_o,
  output logic             slot_start_o,
  output logic             fetch_ok_o
);
  logic [BIT_W-1:0] bit_q;
  chan_e            chan_q;
  logic             zero_q;
  logic             last_bit_w;

  assign last_bit_w   = (bit_q == width_i - BIT_W'(1));
  assign slot_start_o = step_i && last_bit_w;
  // the load for the left slot of frame two happens while the zero frame is still active
  assign fetch_ok_o   = !zero_q || (chan_q == CH_RIGHT);
  assign ws_o         = chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      chan_q <= CH_LEFT;
      zero_q <= 1'b1;
    end else if (!run_i) begin
      bit_q  <= '0;
      chan_q <= CH_LEFT;
      zero_q <= 1'b1;
    end else if (step_i) begin
      if (last_bit_w) begin
        bit_q <= '0;
        if (chan_q == CH_RIGHT) begin
          chan_q <= CH_LEFT;
          zero_q <= 1'b0;
        end else begin
          chan_q <= CH_RIGHT;
        end
      end else begin
        bit_q <= bit_q + BIT_W'(1);
      end
    end
  end

endmodule
// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
  parameter int DATA_W = 32,
  parameter int BIT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [BIT_W-1:0]  width_i,
  output logic              sd_o
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] align_w;
  logic [BIT_W-1:0]  shamt_w;

  // sample MSB moves to the top, bits above the width fall off
  assign shamt_w = BIT_W'(DATA_W) - width_i;
  assign align_w = word_i << shamt_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      sd_o <= 1'b0;
    end else if (!run_i) begin
      sh_q <= '0;
      sd_o <= 1'b0;
    end else if (step_i) begin
      sd_o <= sh_q[DATA_W-1];
      sh_q <= load_i ? align_w : (sh_q << 1);
    end
  end

endmodule
// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic [DATA_W-1:0]  fifo_data_i,
  input  logic               fifo_empty_i,
  output logic               fifo_pop_o,
  output logic               sck_o,
  output logic               ws_o,
  output logic               sd_o
);
  localparam int BIT_W = $clog2(DATA_W) + 1;

  logic [RATIO_W-1:0] ratio_q;
  logic [BIT_W-1:0]   width_q;
  logic [BIT_W-1:0]   width_d;
  logic               fall_w;
  logic               slot_start_w;
  logic               fetch_ok_w;
  logic [DATA_W-1:0]  load_word_w;

  always_comb width_d = BIT_W'(clamp_width(32'(res_i), DATA_W));

  // configuration is frozen while transmitting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= '0;
      width_q <= BIT_W'(DATA_W);
    end else if (!tx_en_i) begin
      ratio_q <= ratio_i;
      width_q <= width_d;
    end
  end

  i2s_tx_clkgen #(
    .RATIO_W(RATIO_W)
  ) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tx_en_i),
    .ratio_i(ratio_q),
    .sck_o  (sck_o),
    .fall_o (fall_w)
  );

  i2s_tx_framer #(
    .BIT_W(BIT_W)
  ) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (tx_en_i),
    .step_i      (fall_w),
    .width_i     (width_q),
    .ws_o        (ws_o),
    .slot_start_o(slot_start_w),
    .fetch_ok_o  (fetch_ok_w)
  );

  assign fifo_pop_o  = slot_start_w && fetch_ok_w && !fifo_empty_i;
  assign load_word_w = fifo_pop_o ? fifo_data_i : '0;

  i2s_tx_shifter #(
    .DATA_W(DATA_W),
    .BIT_W (BIT_W)
  ) u_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tx_en_i),
    .step_i (fall_w),
    .load_i (slot_start_w),
    .word_i (load_word_w),
    .width_i(width_q),
    .sd_o   (sd_o)
  );

endmodule
// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic fifo_empty_i,
  input logic fifo_pop_o,
  input logic sck_o,
  input logic ws_o,
  input logic sd_o
);

  assert_idle_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (!sck_o && !ws_o && !sd_o && !fifo_pop_o));

  assert_ws_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_en_i) && !$stable(ws_o)) |-> $fell(sck_o));

  assert_sd_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_en_i) && !$stable(sd_o)) |-> $fell(sck_o));

  assert_no_pop_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);

  assert_pop_before_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (tx_en_i && sck_o));

  assert_pop_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !fifo_pop_o);

endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en_i     (tx_en_i),
  .fifo_empty_i(fifo_empty_i),
  .fifo_pop_o  (fifo_pop_o),
  .sck_o       (sck_o),
  .ws_o        (ws_o),
  .sd_o        (sd_o)
);
// File: tb/i2s_tx_serializer_bench.sv
`timescale 1ns/1ps
module i2s_tx_serializer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_en_i = 1'b0;
  logic [7:0]  ratio_i = '0;
  logic [5:0]  res_i = '0;
  logic [31:0] fifo_data_i;
  logic        fifo_empty_i;
  logic        fifo_pop_o, sck_o, ws_o, sd_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] fmem [0:15];
  int fcount = 0;
  int pops = 0;
  int base = 0;
  int rd_idx;

  always #10 clk_i = ~clk_i;

  i2s_tx_serializer u_i2s_tx_serializer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .ratio_i(ratio_i), .res_i(res_i),
    .fifo_data_i(fifo_data_i), .fifo_empty_i(fifo_empty_i), .fifo_pop_o(fifo_pop_o),
    .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o));

  // show-ahead FIFO model
  assign rd_idx       = pops - base;
  assign fifo_empty_i = (rd_idx >= fcount);
  assign fifo_data_i  = fmem[rd_idx[3:0]];
  always @(posedge clk_i) if (fifo_pop_o) pops <= pops + 1;

  // {ratio, res, words, frames}
  localparam logic [31:0] VEC [0:7] = '{
    32'h00_20_04_04, 32'h02_10_06_04, 32'h01_18_05_04, 32'hFF_08_02_03,
    32'h05_00_03_03, 32'h03_01_06_06, 32'h00_28_02_03, 32'h04_0C_00_03};

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input int s);
    if (s < 2) return 32'h0;
    if (s - 2 < fcount) return fmem[s-2];
    return 32'h0;
  endfunction

  task automatic run_vec(input int ratio, input int res, input int nw, input int frames, input logic [31:0] seed);
    int w, nbits, half, n, cyc, last, first_pop, slot, pos, lim;
    logic prev, exp_ws, exp_sd;
    logic [31:0] wd;
    w = (res == 0 || res > 32) ? 32 : res;
    nbits = frames * 2 * w;
    half = ratio + 2;
    tx_en_i = 1'b0;
    @(negedge clk_i);
    for (int k = 0; k < 16; k++) fmem[k] = (32'(k) + 32'd1) * 32'h9E3779B9 ^ seed;
    fcount = nw;
    base = pops;
    ratio_i = 8'(ratio);
    res_i = 6'(res);
    @(negedge clk_i);
    @(negedge clk_i);
    tx_en_i = 1'b1;
    n = 0; cyc = 0; last = 0; first_pop = -1; prev = 1'b0;
    while (n < nbits) begin
      @(negedge clk_i);
      cyc++;
      if (fifo_pop_o && first_pop < 0) first_pop = n;
      if (sck_o && !prev) begin
        if (n == 0) check("R1 first rise delay", cyc, half);
        else check("R1 bit clock period", cyc - last, 2 * half);
        last = cyc;
        slot = n / w;
        pos = n % w;
        exp_ws = slot[0];
        if (pos == 0) begin wd = word_at(slot - 1); exp_sd = wd[0]; end
        else begin wd = word_at(slot); exp_sd = wd[w - pos]; end
        // R2 R3 R4 R6: framing, alignment, zero frame, underrun
        check($sformatf("R2/R3 ws,sd at bit %0d", n), {ws_o, sd_o}, {exp_ws, exp_sd});
        n++;
      end
      prev = sck_o;
    end
    tx_en_i = 1'b0;
    @(negedge clk_i);
    lim = 2 * frames - 2;
    check("R5 words consumed", pops - base, (nw < lim) ? nw : lim);
    check("R4 first pop at rise 2W", first_pop, (nw > 0) ? 2 * w : -1);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, cyc, last;
    logic prev;
    for (int k = 0; k < 16; k++) fmem[k] = '0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R9 reset outputs", {sck_o, ws_o, sd_o, fifo_pop_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < 8; v++)
      run_vec(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]),
              32'hA5C3_0000 + 32'(v));

    // R8: ratio and resolution changes while enabled are ignored
    fcount = 0; base = pops;
    ratio_i = 8'd1; res_i = 6'd16;
    @(negedge clk_i);
    @(negedge clk_i);
    tx_en_i = 1'b1;
    n = 0; cyc = 0; last = 0; prev = 1'b0;
    while (n < 18) begin
      @(negedge clk_i);
      cyc++;
      if (sck_o && !prev) begin
        if (n == 3) begin ratio_i = 8'd9; res_i = 6'd4; end
        if (n > 4) check("R8 period unchanged", cyc - last, 6);
        if (n == 15) check("R8 ws still left at bit 15", ws_o, 0);
        if (n == 16) check("R8 ws right at bit 16", ws_o, 1);
        last = cyc;
        n++;
      end
      prev = sck_o;
    end

    // R7: disabling mid-stream idles everything at once
    fcount = 8;
    for (int k = 0; k < 8; k++) fmem[k] = 32'hFFFF_FFFF;
    repeat (150) @(negedge clk_i);
    tx_en_i = 1'b0;
    @(negedge clk_i);
    check("R7 idle after disable", {sck_o, ws_o, sd_o, fifo_pop_o}, 0);
    repeat (20) @(negedge clk_i);
    check("R7 idle stays", {sck_o, ws_o, sd_o, fifo_pop_o}, 0);

    // R9: asynchronous reset while running
    ratio_i = 8'd0; res_i = 6'd8;
    @(negedge clk_i);
    tx_en_i = 1'b1;
    repeat (40) @(negedge clk_i);
    #3 rst_ni = 1'b0;
    #2 check("R9 async reset idles", {sck_o, ws_o, sd_o}, 0);
    tx_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule